// File: doc/BRIEF.md
# Interleaved CPU/Video DRAM Slot Sequencer

This block times a shared DRAM array that is used by both a processor and a display fetch engine. It runs from an 8 MHz master clock and splits every 2 MHz processor cycle into two back-to-back DRAM cycles. The first of the pair is a video slot and the second is a CPU slot. Within each slot it drives the row strobe, gates the per-bank column strobe, steers a six-way row/column address multiplexer and qualifies the write strobe. During the CPU slot it also enables the buffer that links the processor data bus to the RAM data bus. The 2 MHz processor clock leaves the block as a divided copy of the slot phase.

The row strobe fires on every slot whether or not a transfer is wanted. Because the display engine walks through enough rows, no separate refresh logic is needed. Column strobes fire only for real RAM transfers. A CPU slot that targets the upper half of the map, which holds ROM or peripherals, gets no column strobe. Neither does a write to the display controller's own registers. That controller sits only on the RAM data bus, so such a write opens the bus link as if it were a RAM write, while the DRAM itself stays untouched.

Each slot lasts two master ticks, which is four half-ticks:
- first half-tick: row strobe low, row address on the multiplexer;
- second half-tick: multiplexer switches to the column half;
- third half-tick: column strobe low;
- fourth half-tick: both strobes high for precharge.

Slot inputs are captured at the master edge that opens the slot.

Top module: `dram_slot_seq`

## Requirements
- R1: `cpuClk` is high during every video slot and low during every CPU slot, so it runs at one quarter of the master clock. It is low while reset is held.
- R2: `rasN` is low in the first three half-ticks of every slot and high in the fourth, on every slot regardless of the access.
- R3: `muxSel` selects the row half in the first half-tick of a slot and the column half in the remaining three. The codes are: 0 CPU row, 1 CPU column, 2 character row, 3 character column, 4 bitmap row, 5 bitmap column.
- R4: `dramAddr` carries source address bits [6:0] when a row code is selected and bits [13:7] when a column code is selected. The source is the address captured at the start of the slot.
- R5: A video slot uses the character-mode address when `charMode` was 1 at slot start, and the bitmap-mode address otherwise.
- R6: `casN` is low only in the third half-tick of a slot. Only bit b may be low, where b is address bit 14 of the slot's source. A video slot always strobes one bank.
- R7: A CPU slot whose `cpuAddr[15]` is 1, or whose `vidRegSel` is 1, leaves `casN` at all ones.
- R8: `weN` is low for the whole CPU slot when `cpuWr` is 1, `cpuAddr[15]` is 0 and `vidRegSel` is 0. It is high in all other cases and in every video slot.
- R9: `linkEn` is high only inside a CPU slot while `cpuDataPhase` is 1, and only when the access is either a RAM access or a write with `vidRegSel` set. It is never high in a video slot.
- R10: A write with `vidRegSel` set raises `linkEn` in its data phase, while `casN` stays all ones and `weN` stays high.
- R11: While `rstN` is low, the outputs are held idle: `rasN`=1, `casN`=all ones, `weN`=1, `linkEn`=0, `muxSel`=0. The first slot after reset is a video slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz master clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuAddr | input | 16 | Processor address, captured at CPU slot start |
| cpuWr | input | 1 | Processor write, captured at CPU slot start |
| cpuDataPhase | input | 1 | Processor is in the data half of its cycle (live) |
| vidRegSel | input | 1 | Decoded hit on the display controller registers |
| charMode | input | 1 | Display uses character-mode addressing |
| charVidAddr | input | 15 | Character-mode video fetch address |
| mapVidAddr | input | 15 | Bitmap-mode video fetch address |
| cpuClk | output | 1 | Divided 2 MHz processor clock |
| rasN | output | 1 | Row strobe to all devices, active low |
| casN | output | 2 | Per-bank column strobe, active low |
| weN | output | 1 | DRAM write strobe, active low |
| muxSel | output | 3 | Six-way address multiplexer select |
| dramAddr | output | 7 | Multiplexed DRAM address |
| linkEn | output | 1 | Enable of the CPU/RAM data bus link buffer |

## Verification
The bench builds the sequencer with its default geometry: 7 row bits, 7 column bits and one bank bit. This gives a 16-bit processor address, where bit 15 splits RAM from the rest of the map and bit 14 picks the bank. Both banks, both video address modes and the ROM/peripheral half are therefore all reachable from random addresses. Each of the four half-ticks of both slot kinds is sampled in isolation. The directed slots cover the display-register write and read, the non-RAM read, and a write whose data phase is held off.

// File: rtl/dram_slot_pkg.sv
package dram_slot_pkg;

  // Strobes the slot controller hands to the address/gating datapath.
  typedef struct packed {
    logic run;      // sequencer has left reset
    logic vidSlot;  // current slot belongs to the display fetch
    logic rasOn;    // row strobe window
    logic colSel;   // column half on the address multiplexer
    logic casOn;    // column strobe window (before bank gating)
    logic loadVid;  // next edge opens a video slot
    logic loadCpu;  // next edge opens a CPU slot
  } slotStb_t;

  typedef enum logic [2:0] {
    MUX_CPU_ROW  = 3'd0,
    MUX_CPU_COL  = 3'd1,
    MUX_CHAR_ROW = 3'd2,
    MUX_CHAR_COL = 3'd3,
    MUX_MAP_ROW  = 3'd4,
    MUX_MAP_COL  = 3'd5
  } muxCode_t;

  function automatic muxCode_t muxPick(input logic vid, input logic charM, input logic col);
    muxCode_t code;
    if (!vid)       code = col ? MUX_CPU_COL  : MUX_CPU_ROW;
    else if (charM) code = col ? MUX_CHAR_COL : MUX_CHAR_ROW;
    else            code = col ? MUX_MAP_COL  : MUX_MAP_ROW;
    return code;
  endfunction

endpackage

// File: rtl/dram_slot_ctrl.sv
module dram_slot_ctrl
  import dram_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  output slotStb_t   stb,
  output logic [1:0] slotCnt
);

  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNeg;
  logic             run;
  logic             lateHalf;
  logic             firstTick;

  // Tick counter: 0-1 video slot, 2-3 CPU slot.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= LAST;
      run <= 1'b0;
    end else begin
      cnt <= cnt + CNT_W'(1);
      run <= 1'b1;
    end
  end

  // Falling-edge copy: equals cnt only in the second half of a tick.
  always_ff @(negedge clk) begin
    if (!rstN) cntNeg <= LAST;
    else       cntNeg <= cnt;
  end

  assign lateHalf  = (cntNeg == cnt);
  assign firstTick = ~cnt[0];

  always_comb begin
    stb.run     = run;
    stb.vidSlot = run & ~cnt[1];
    stb.rasOn   = run & (firstTick | ~lateHalf);
    stb.colSel  = run & (~firstTick | lateHalf);
    stb.casOn   = run & ~firstTick & ~lateHalf;
    stb.loadVid = (cnt == LAST);
    stb.loadCpu = run & (cnt == CNT_W'(1));
  end

  assign slotCnt = cnt;

endmodule

// File: rtl/dram_slot_path.sv
module dram_slot_path
  import dram_slot_pkg::*;
#(
  parameter int ROW_W     = 7,
  parameter int COL_W     = 7,
  parameter int BANK_BITS = 1,
  localparam int NBANK    = 2 ** BANK_BITS,
  localparam int VID_AW   = ROW_W + COL_W + BANK_BITS,
  localparam int CPU_AW   = VID_AW + 1,
  localparam int DA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStb_t          stb,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuDataPhase,
  input  logic              vidRegSel,
  input  logic              charMode,
  input  logic [VID_AW-1:0] charVidAddr,
  input  logic [VID_AW-1:0] mapVidAddr,
  output logic [2:0]        muxSel,
  output logic [DA_W-1:0]   dramAddr,
  output logic [NBANK-1:0]  casN,
  output logic              weN,
  output logic              linkEn,
  output logic              vidRegWr
);

  logic [VID_AW-1:0]    vidAddrQ;
  logic                 charQ;
  logic [VID_AW-1:0]    cpuAddrQ;
  logic                 ramHitQ;
  logic                 cpuWrQ;
  logic                 vidRegWrQ;

  logic [VID_AW-1:0]    srcAddr;
  logic [ROW_W-1:0]     rowPart;
  logic [COL_W-1:0]     colPart;
  logic [BANK_BITS-1:0] bankIdx;
  logic                 cpuSlot;
  logic                 accessOn;

  // Video source captured at the edge that opens the video slot.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidAddrQ <= '0;
      charQ    <= 1'b0;
    end else if (stb.loadVid) begin
      vidAddrQ <= charMode ? charVidAddr : mapVidAddr;
      charQ    <= charMode;
    end
  end

  // Processor request captured at the edge that opens the CPU slot.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuAddrQ  <= '0;
      ramHitQ   <= 1'b0;
      cpuWrQ    <= 1'b0;
      vidRegWrQ <= 1'b0;
    end else if (stb.loadCpu) begin
      cpuAddrQ  <= cpuAddr[VID_AW-1:0];
      ramHitQ   <= ~cpuAddr[CPU_AW-1] & ~vidRegSel;
      cpuWrQ    <= cpuWr;
      vidRegWrQ <= vidRegSel & cpuWr;
    end
  end

  assign cpuSlot  = stb.run & ~stb.vidSlot;
  assign srcAddr  = stb.vidSlot ? vidAddrQ : cpuAddrQ;
  assign rowPart  = srcAddr[ROW_W-1:0];
  assign colPart  = srcAddr[ROW_W +: COL_W];
  assign bankIdx  = srcAddr[ROW_W+COL_W +: BANK_BITS];
  assign accessOn = stb.vidSlot | (cpuSlot & ramHitQ);

  assign muxSel   = muxPick(stb.vidSlot, charQ, stb.colSel);
  assign dramAddr = stb.colSel ? DA_W'(colPart) : DA_W'(rowPart);

  for (genvar b = 0; b < NBANK; b++) begin : g_bankCas
    assign casN[b] = ~(stb.casOn & accessOn & (bankIdx == BANK_BITS'(b)));
  end

  assign weN      = ~(cpuSlot & cpuWrQ & ramHitQ);
  assign linkEn   = cpuSlot & cpuDataPhase & (ramHitQ | vidRegWrQ);
  assign vidRegWr = vidRegWrQ;

endmodule

// File: rtl/dram_slot_seq.sv
module dram_slot_seq
  import dram_slot_pkg::*;
#(
  parameter int ROW_W     = 7,
  parameter int COL_W     = 7,
  parameter int BANK_BITS = 1,
  localparam int NBANK    = 2 ** BANK_BITS,
  localparam int VID_AW   = ROW_W + COL_W + BANK_BITS,
  localparam int CPU_AW   = VID_AW + 1,
  localparam int DA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuDataPhase,
  input  logic              vidRegSel,
  input  logic              charMode,
  input  logic [VID_AW-1:0] charVidAddr,
  input  logic [VID_AW-1:0] mapVidAddr,
  output logic              cpuClk,
  output logic              rasN,
  output logic [NBANK-1:0]  casN,
  output logic              weN,
  output logic [2:0]        muxSel,
  output logic [DA_W-1:0]   dramAddr,
  output logic              linkEn
);

  slotStb_t   stb;
  logic [1:0] slotCnt;
  logic       seqRun;
  logic       vidRegWr;

  dram_slot_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .slotCnt (slotCnt)
  );

  dram_slot_path #(
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .BANK_BITS (BANK_BITS)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cpuAddr      (cpuAddr),
    .cpuWr        (cpuWr),
    .cpuDataPhase (cpuDataPhase),
    .vidRegSel    (vidRegSel),
    .charMode     (charMode),
    .charVidAddr  (charVidAddr),
    .mapVidAddr   (mapVidAddr),
    .muxSel       (muxSel),
    .dramAddr     (dramAddr),
    .casN         (casN),
    .weN          (weN),
    .linkEn       (linkEn),
    .vidRegWr     (vidRegWr)
  );

  assign seqRun = stb.run;
  assign rasN   = ~stb.rasOn;
  assign cpuClk = stb.vidSlot;

endmodule

// File: rtl/dram_slot_seq_chk.sv
module dram_slot_seq_chk #(
  parameter int NBANK = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       slotCnt,
  input logic             seqRun,
  input logic             rasN,
  input logic [NBANK-1:0] casN,
  input logic             weN,
  input logic             linkEn,
  input logic             cpuClk,
  input logic             vidRegWr
);

  // R2: row strobe low in the first half of every tick
  a_r2_ras_early: assert property (@(negedge clk) disable iff (!rstN)
    seqRun |-> !rasN);

  // R2: precharge in the second half of the second tick of each slot
  a_r2_ras_precharge: assert property (@(posedge clk) disable iff (!rstN)
    (seqRun && slotCnt[0]) |-> rasN);

  // R6: column strobe only under row strobe, in the second tick
  a_r6_cas_window: assert property (@(negedge clk) disable iff (!rstN)
    (casN != '1) |-> (slotCnt[0] && !rasN));

  // R6: column strobe released in every late half-tick
  a_r6_cas_off_late: assert property (@(posedge clk) disable iff (!rstN)
    seqRun |-> (casN == '1));

  // R6: at most one bank strobed
  a_r6_one_bank: assert property (@(negedge clk) disable iff (!rstN)
    $onehot0(~casN));

  // R1: processor clock low through the CPU slot
  a_r1_clk_low_cpu: assert property (@(posedge clk) disable iff (!rstN)
    (seqRun && slotCnt == 2'd1) |=> !cpuClk);

  // R9: link only in the CPU slot
  a_r9_link_cpu_only: assert property (@(negedge clk) disable iff (!rstN)
    linkEn |-> (seqRun && !cpuClk));

  // R10: register write through the link leaves the DRAM alone
  a_r10_vidreg_no_dram: assert property (@(negedge clk) disable iff (!rstN)
    (linkEn && vidRegWr) |-> (casN == '1 && weN));

endmodule

bind dram_slot_seq dram_slot_seq_chk #(.NBANK(NBANK)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .slotCnt  (slotCnt),
  .seqRun   (seqRun),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .linkEn   (linkEn),
  .cpuClk   (cpuClk),
  .vidRegWr (vidRegWr)
);

// File: tb/dram_slot_seq_test.sv
module dram_slot_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuWr = 1'b0;
  logic        cpuDataPhase = 1'b0;
  logic        vidRegSel = 1'b0;
  logic        charMode = 1'b0;
  logic [14:0] charVidAddr = '0;
  logic [14:0] mapVidAddr = '0;
  logic        cpuClk, rasN, weN, linkEn;
  logic [1:0]  casN;
  logic [2:0]  muxSel;
  logic [6:0]  dramAddr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // captured copies of what the design should have latched
  logic [14:0] lVid;
  logic        lChar;
  logic [15:0] lCpu;
  logic        lWr, lVr;

  dram_slot_seq uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr),
    .cpuDataPhase(cpuDataPhase), .vidRegSel(vidRegSel), .charMode(charMode),
    .charVidAddr(charVidAddr), .mapVidAddr(mapVidAddr), .cpuClk(cpuClk),
    .rasN(rasN), .casN(casN), .weN(weN), .muxSel(muxSel),
    .dramAddr(dramAddr), .linkEn(linkEn)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] expMux(input bit vid, input logic charM, input bit col);
    logic [1:0] src;
    src = !vid ? 2'd0 : (charM ? 2'd1 : 2'd2);
    return {src, 1'b0} + {2'b0, col};
  endfunction

  function automatic logic [6:0] expAddr(input logic [14:0] a, input bit col);
    return col ? a[13:7] : a[6:0];
  endfunction

  function automatic bit ramHit(input logic [15:0] a, input logic vr);
    return !a[15] && !vr;
  endfunction

  function automatic logic [1:0] expCas(input int q, input bit vid,
                                        input logic [14:0] src, input bit hit);
    if (q != 2 || !(vid || hit)) return 2'b11;
    return src[14] ? 2'b01 : 2'b10;
  endfunction

  task automatic setNext(input int idx);
    charVidAddr  = 15'($urandom);
    mapVidAddr   = 15'($urandom);
    charMode     = 1'($urandom);
    cpuAddr      = 16'($urandom);
    cpuWr        = 1'($urandom);
    cpuDataPhase = ($urandom % 4) != 0;
    vidRegSel    = cpuAddr[15] && (($urandom % 4) == 0);
    case (idx)
      0: begin cpuAddr = 16'h0123; cpuWr = 0; vidRegSel = 0; cpuDataPhase = 1; charMode = 1; end
      1: begin cpuAddr = 16'h4F0A; cpuWr = 1; vidRegSel = 0; cpuDataPhase = 1; charMode = 0; end
      2: begin cpuAddr = 16'hC000; cpuWr = 0; vidRegSel = 0; cpuDataPhase = 1; end
      3: begin cpuAddr = 16'hFE21; cpuWr = 1; vidRegSel = 1; cpuDataPhase = 1; end
      4: begin cpuAddr = 16'hFE21; cpuWr = 0; vidRegSel = 1; cpuDataPhase = 1; end
      5: begin cpuAddr = 16'h3FFF; cpuWr = 1; vidRegSel = 0; cpuDataPhase = 0; end
      6: begin cpuAddr = 16'h7FFF; cpuWr = 1; vidRegSel = 0; cpuDataPhase = 1; end
      default: ;
    endcase
  endtask

  task automatic doSlot(input bit vid, input int idx);
    logic [14:0] src;
    bit hit, col;
    @(posedge clk);
    if (vid) begin lVid = charMode ? charVidAddr : mapVidAddr; lChar = charMode; end
    else begin lCpu = cpuAddr; lWr = cpuWr; lVr = vidRegSel; end
    src = vid ? lVid : lCpu[14:0];
    hit = ramHit(lCpu, lVr);
    for (int q = 0; q < 4; q++) begin
      if (q == 0) #1; else #2;
      col = (q != 0);
      check("R1", "cpuClk", cpuClk, vid);
      check("R2", "rasN", rasN, q == 3);
      check(vid ? "R5" : "R3", "muxSel", muxSel, expMux(vid, lChar, col));
      check("R4", "dramAddr", dramAddr, expAddr(src, col));
      check(vid ? "R6" : "R7", "casN", casN, expCas(q, vid, src, hit));
      check("R8", "weN", weN, !(!vid && lWr && hit));
      check(lVr ? "R10" : "R9", "linkEn", linkEn,
            !vid && cpuDataPhase && (hit || (lVr && lWr)));
    end
    setNext(idx);
  endtask

  initial begin
    void'($urandom(32'd1234));
    setNext(100);
    repeat (3) @(posedge clk);
    #1;
    check("R11", "rasN", rasN, 1);
    check("R11", "casN", casN, 2'b11);
    check("R11", "weN", weN, 1);
    check("R11", "linkEn", linkEn, 0);
    check("R11", "muxSel", muxSel, 0);
    check("R1", "cpuClk reset", cpuClk, 0);
    rstN = 1'b1;
    setNext(0);
    for (int i = 0; i < 600; i++) begin
      doSlot(1'b1, i);       // video slot first after reset (R11)
      doSlot(1'b0, i + 1);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule